// File: doc/BRIEF.md
# Dual-Bank Input Gamma Table

This block maps each 8-bit colour channel of an incoming pixel through its own 256-entry table and returns a 12-bit unsigned fraction per channel. The fraction is in 0.12 fixed point. The table storage has two banks, A and B. While one bank feeds the pixel path, the host fills the other bank. The host then changes the mode so the pixel path uses the freshly written bank, which gives tear-free table updates.

The host writes through a single sequential colour port. It first loads an index. Each write after that fills one channel of the current entry, in the order red, green, blue. After the blue slot the index moves to the next entry. A three-bit channel mask can suppress the storing of individual channels. A masked slot is still consumed, so the order of writes never shifts.

Pixels wider than 8 bits per channel are truncated to their upper 8 bits. A bypass mode sends the index straight through, left-aligned to 12 bits. A small status code reports which bank is live.

Top module: `in_gamma_lut`

## Requirements
- R1: After reset `out_valid` is 0, all three outputs are 0, and the write sequencer points at entry 0, red slot.
- R2: A pixel presented with `pix_valid` high at a clock edge produces its result and `out_valid`=1 at that edge. `out_valid` is 0 after every edge at which `pix_valid` was low.
- R3: Each channel uses only its upper 8 bits (`pix_x[IN_W-1 -: 8]`) as the table index. The lower bits have no effect on the result.
- R4: With `cfg_mode` 0 or 1 (bypass), each output is {i, i[7:4]}, where i is the channel's 8-bit index.
- R5: With `cfg_mode`=2, each output is bank A's entry for that channel at index i. With `cfg_mode`=3, it is bank B's entry.
- R6: Colour-port writes fill the red, green and blue slots of the current entry in that order, then the index increments. Index 255 wraps to 0.
- R7: An index load sets the index and returns the slot to red. A colour write in the same cycle as an index load is dropped.
- R8: `cfg_wbank`=0 sends colour writes to bank A and 1 sends them to bank B. The other bank is left unchanged.
- R9: Mask bit 0 enables red, bit 1 enables green and bit 2 enables blue. A masked slot stores nothing but still advances the sequencer.
- R10: `status` is 1 when bank A is live (mode 2), 2 when bank B is live (mode 3), and 0 in bypass.
- R11: Writes to the bank that is not live do not change pixel results until the mode selects that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0/1 bypass, 2 bank A live, 3 bank B live |
| cfg_wbank | input | 1 | Write target bank: 0 A, 1 B |
| cfg_wmask | input | 3 | Channel write enables: bit0 R, bit1 G, bit2 B |
| host_idx_wr | input | 1 | Load write index strobe |
| host_idx | input | 8 | Index value to load |
| host_col_wr | input | 1 | Colour-port write strobe |
| host_col | input | 12 | Colour-port data, 0.12 |
| status | output | 3 | Live bank code |
| pix_valid | input | 1 | Pixel input valid |
| pix_r | input | IN_W | Red input |
| pix_g | input | IN_W | Green input |
| pix_b | input | IN_W | Blue input |
| out_valid | output | 1 | Result valid |
| out_r | output | 12 | Red result |
| out_g | output | 12 | Green result |
| out_b | output | 12 | Blue result |

## Verification
The bench targets the sequencer's slot handling. A masked green-only write that stored into the wrong entry, or that failed to consume the red and blue slots, would misplace the next red value. An index load in the middle of an entry that kept the old slot would put red data into green. A colour write that beat a simultaneous index load would corrupt the new entry. The bench also wraps the index from 255 to 0 and checks that low input bits are ignored. Finally it writes the idle bank while the other is live: a design that mixed up bank selection would show the new values before the mode switch.

// File: rtl/in_gamma_pkg.sv
package in_gamma_pkg;
    localparam int LUT_AW = 8;
    localparam int LUT_DW = 12;
    localparam int N_CH   = 3;

    typedef enum logic [1:0] {
        MODE_BYP  = 2'd0,
        MODE_BYP1 = 2'd1,
        MODE_A    = 2'd2,
        MODE_B    = 2'd3
    } lut_mode_e;

    typedef enum logic [1:0] {
        SLOT_R = 2'd0,
        SLOT_G = 2'd1,
        SLOT_B = 2'd2
    } slot_e;
endpackage

// File: rtl/in_gamma_wseq.sv
module in_gamma_wseq
    import in_gamma_pkg::*;
#(
    parameter int AW = LUT_AW,
    parameter int DW = LUT_DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idx_wr,
    input  logic [AW-1:0]   idx_val,
    input  logic            col_wr,
    input  logic [DW-1:0]   col_data,
    input  logic [N_CH-1:0] wmask,
    output logic [N_CH-1:0] we_ch,
    output logic [AW-1:0]   waddr,
    output logic [DW-1:0]   wdata
);
    typedef struct packed {
        logic [AW-1:0] idx;
        slot_e         slot;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        we_ch = '0;
        if (idx_wr) begin
            s_d.idx  = idx_val;
            s_d.slot = SLOT_R;
        end else if (col_wr) begin
            we_ch = (N_CH'(1) << s_q.slot) & wmask;
            if (s_q.slot == SLOT_B) begin
                s_d.slot = SLOT_R;
                s_d.idx  = s_q.idx + AW'(1);
            end else begin
                s_d.slot = slot_e'(s_q.slot + 2'd1);
            end
        end
    end

    assign waddr = s_q.idx;
    assign wdata = col_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.idx  <= '0;
            s_q.slot <= SLOT_R;
        end else begin
            s_q <= s_d;
        end
    end

    // R7
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (s_q.idx == $past(idx_val)) && (s_q.slot == SLOT_R));

    // R6
    idx_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_wr && !idx_wr && s_q.slot == SLOT_B) |=>
            (s_q.idx == $past(s_q.idx) + AW'(1)) && (s_q.slot == SLOT_R));

    // R9
    one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_ch));
endmodule

// File: rtl/in_gamma_banks.sv
module in_gamma_banks
    import in_gamma_pkg::*;
#(
    parameter int AW     = LUT_AW,
    parameter int DW     = LUT_DW,
    parameter int N_BANK = 2
) (
    input  logic                                  clk,
    input  logic                                  wbank,
    input  logic [N_CH-1:0]                       we_ch,
    input  logic [AW-1:0]                         waddr,
    input  logic [DW-1:0]                         wdata,
    input  logic [N_CH-1:0][AW-1:0]               raddr,
    output logic [N_BANK-1:0][N_CH-1:0][DW-1:0]   rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            logic [DW-1:0] mem [DEPTH];
            always_ff @(posedge clk) begin
                if (we_ch[c] && (int'(wbank) == b)) begin
                    mem[waddr] <= wdata;
                end
            end
            assign rdata[b][c] = mem[raddr[c]];
        end
    end
endmodule

// File: rtl/in_gamma_lut.sv
module in_gamma_lut
    import in_gamma_pkg::*;
#(
    parameter int IN_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_wbank,
    input  logic [2:0]        cfg_wmask,
    input  logic              host_idx_wr,
    input  logic [7:0]        host_idx,
    input  logic              host_col_wr,
    input  logic [11:0]       host_col,
    output logic [2:0]        status,
    input  logic              pix_valid,
    input  logic [IN_W-1:0]   pix_r,
    input  logic [IN_W-1:0]   pix_g,
    input  logic [IN_W-1:0]   pix_b,
    output logic              out_valid,
    output logic [11:0]       out_r,
    output logic [11:0]       out_g,
    output logic [11:0]       out_b
);
    localparam int AW  = LUT_AW;
    localparam int DW  = LUT_DW;
    localparam int PAD = DW - AW;

    typedef struct packed {
        logic                      vld;
        logic [N_CH-1:0][DW-1:0]   px;
    } rd_t;

    logic [N_CH-1:0]             we_ch;
    logic [AW-1:0]               waddr;
    logic [DW-1:0]               wdata;
    logic [N_CH-1:0][AW-1:0]     raddr;
    logic [1:0][N_CH-1:0][DW-1:0] rdata;
    rd_t                         r_d, r_q;

    in_gamma_wseq #(.AW(AW), .DW(DW)) u_wseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (host_idx_wr),
        .idx_val  (host_idx),
        .col_wr   (host_col_wr),
        .col_data (host_col),
        .wmask    (cfg_wmask),
        .we_ch    (we_ch),
        .waddr    (waddr),
        .wdata    (wdata)
    );

    assign raddr[0] = pix_r[IN_W-1 -: AW];
    assign raddr[1] = pix_g[IN_W-1 -: AW];
    assign raddr[2] = pix_b[IN_W-1 -: AW];

    in_gamma_banks #(.AW(AW), .DW(DW), .N_BANK(2)) u_banks (
        .clk   (clk),
        .wbank (cfg_wbank),
        .we_ch (we_ch),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = pix_valid;
        if (pix_valid) begin
            for (int c = 0; c < N_CH; c++) begin
                case (lut_mode_e'(cfg_mode))
                    MODE_A:  r_d.px[c] = rdata[0][c];
                    MODE_B:  r_d.px[c] = rdata[1][c];
                    default: r_d.px[c] = {raddr[c], raddr[c][AW-1 -: PAD]};
                endcase
            end
        end
    end

    always_comb begin
        case (lut_mode_e'(cfg_mode))
            MODE_A:  status = 3'd1;
            MODE_B:  status = 3'd2;
            default: status = 3'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.vld;
    assign out_r     = r_q.px[0];
    assign out_g     = r_q.px[1];
    assign out_b     = r_q.px[2];

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    // R4
    bypass_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !cfg_mode[1]) |=>
            out_g == {$past(pix_g[IN_W-1 -: AW]), $past(pix_g[IN_W-1 -: PAD])});

    // R10
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 3'd0) |-> (cfg_mode[1] && status == {1'b0, cfg_mode[0], !cfg_mode[0]}));
endmodule

// File: tb/in_gamma_lut_bench.sv
module in_gamma_lut_bench;
    localparam int IN_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_wbank = 1'b0;
    logic [2:0]  cfg_wmask = 3'd7;
    logic        host_idx_wr = 1'b0;
    logic [7:0]  host_idx = '0;
    logic        host_col_wr = 1'b0;
    logic [11:0] host_col = '0;
    logic [2:0]  status;
    logic        pix_valid = 1'b0;
    logic [IN_W-1:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic        out_valid;
    logic [11:0] out_r, out_g, out_b;

    always #2 clk = ~clk;

    in_gamma_lut #(.IN_W(IN_W)) u_in_gamma_lut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wbank(cfg_wbank),
        .cfg_wmask(cfg_wmask), .host_idx_wr(host_idx_wr), .host_idx(host_idx),
        .host_col_wr(host_col_wr), .host_col(host_col), .status(status),
        .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [11:0] mm [2][3][256];
    logic [7:0]  m_idx = 0;
    int          m_slot = 0;

    // bit fields: [31:30] mode, [29:20] red, [19:10] green, [9:0] blue
    localparam logic [31:0] VEC [8] = '{
        {2'd2, 10'h000, 10'h3FF, 10'h155},
        {2'd2, 10'h2A3, 10'h041, 10'h3FC},
        {2'd3, 10'h001, 10'h3FE, 10'h200},
        {2'd3, 10'h1F7, 10'h0C2, 10'h333},
        {2'd0, 10'h3FF, 10'h000, 10'h2A5},
        {2'd1, 10'h10C, 10'h3B3, 10'h077},
        {2'd2, 10'h003, 10'h002, 10'h001},
        {2'd3, 10'h3FD, 10'h3FC, 10'h3FF}
    };

    function automatic logic [11:0] gen(int b, int c, int i);
        return 12'(((i * 37 + c * 1365 + b * 2730) ^ (i << 2)) & 12'hFFF);
    endfunction

    function automatic logic [11:0] expv(logic [1:0] md, int c, logic [IN_W-1:0] v);
        logic [7:0] i;
        i = v[IN_W-1 -: 8];
        if (md == 2'd2) return mm[0][c][i];
        if (md == 2'd3) return mm[1][c][i];
        return {i, i[7:4]};
    endfunction

    task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host(logic iw, logic [7:0] iv, logic cw, logic [11:0] cd);
        @(negedge clk);
        host_idx_wr = iw; host_idx = iv; host_col_wr = cw; host_col = cd;
        if (iw) begin
            m_idx = iv; m_slot = 0;
        end else if (cw) begin
            if (cfg_wmask[m_slot]) mm[cfg_wbank][m_slot][m_idx] = cd;
            if (m_slot == 2) begin m_slot = 0; m_idx = m_idx + 8'd1; end
            else m_slot = m_slot + 1;
        end
        @(negedge clk);
        host_idx_wr = 0; host_col_wr = 0;
    endtask

    task automatic look(string tag, logic [1:0] md, logic [IN_W-1:0] r, g, b);
        @(negedge clk);
        cfg_mode = md; pix_valid = 1; pix_r = r; pix_g = g; pix_b = b;
        @(negedge clk);
        pix_valid = 0;
        chk(tag, {out_r, out_g, out_b},
            {expv(md, 0, r), expv(md, 1, g), expv(md, 2, b)});
        chk({tag, " valid R2"}, {35'd0, out_valid}, 36'd1);
    endtask

    function automatic logic [IN_W-1:0] at(int e);
        return IN_W'(e << (IN_W - 8));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state, R10 bypass status
        chk("R1 outputs", {out_valid, out_r, out_g, out_b}, 37'd0);
        chk("R10 bypass status", {33'd0, status}, 36'd0);
        @(negedge clk);
        chk("R2 idle valid", {35'd0, out_valid}, 36'd0);

        // R1: sequencer starts at entry 0 red without an index load
        cfg_wbank = 0; cfg_wmask = 3'd7;
        host(0, 0, 1, 12'hA11); host(0, 0, 1, 12'hB22); host(0, 0, 1, 12'hC33);
        look("R1 first entry", 2'd2, at(0), at(0), at(0));

        // program both banks fully: R6 R8
        for (int b = 0; b < 2; b++) begin
            cfg_wbank = b[0];
            host(1, 8'd0, 0, 0);
            for (int i = 0; i < 256; i++)
                for (int c = 0; c < 3; c++) host(0, 0, 1, gen(b, c, i));
        end

        // table of vectors: R3 R4 R5 R10
        for (int k = 0; k < 8; k++) begin
            logic [31:0] v;
            v = VEC[k];
            look($sformatf("R5 R3 R4 vector %0d", k), v[31:30], v[29:20], v[19:10], v[9:0]);
            chk($sformatf("R10 status vector %0d", k), {33'd0, status},
                {33'd0, (v[31:30] == 2'd2) ? 3'd1 : (v[31:30] == 2'd3) ? 3'd2 : 3'd0});
        end

        // R9 mask: green only at entry 5, then next write lands at entry 6 red
        cfg_wbank = 0; cfg_wmask = 3'b010;
        host(1, 8'd5, 0, 0);
        host(0, 0, 1, 12'h111); host(0, 0, 1, 12'h222); host(0, 0, 1, 12'h333);
        cfg_wmask = 3'd7;
        host(0, 0, 1, 12'h444);
        look("R9 masked entry 5", 2'd2, at(5), at(5), at(5));
        look("R9 slot consumed entry 6", 2'd2, at(6), at(6), at(6));

        // R7 index load mid-entry returns to red
        host(1, 8'd20, 0, 0); host(0, 0, 1, 12'h555);
        host(1, 8'd30, 0, 0); host(0, 0, 1, 12'h666);
        look("R7 entry 20", 2'd2, at(20), at(20), at(20));
        look("R7 entry 30 red", 2'd2, at(30), at(30), at(30));

        // R7 simultaneous load and colour write: colour write dropped
        host(1, 8'd40, 1, 12'h777); host(0, 0, 1, 12'h888);
        look("R7 simultaneous entry 40", 2'd2, at(40), at(40), at(40));

        // R6 wrap 255 -> 0
        host(1, 8'd255, 0, 0);
        host(0, 0, 1, 12'h901); host(0, 0, 1, 12'h902); host(0, 0, 1, 12'h903);
        host(0, 0, 1, 12'h904);
        look("R6 entry 255", 2'd2, at(255), at(255), at(255));
        look("R6 wrap entry 0", 2'd2, 10'h003, 10'h001, 10'h002);

        // R11 R8 ping-pong: write bank B while A is live
        cfg_mode = 2'd2; cfg_wbank = 1;
        host(1, 8'd10, 0, 0);
        host(0, 0, 1, 12'hF01); host(0, 0, 1, 12'hF02); host(0, 0, 1, 12'hF03);
        look("R11 live bank A unchanged", 2'd2, at(10), at(10), at(10));
        look("R8 bank B updated", 2'd3, at(10), at(10), at(10));
        chk("R8 new values", {out_r, out_g, out_b}, {12'hF01, 12'hF02, 12'hF03});
        chk("R10 status B", {33'd0, status}, 36'd2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule